// File: doc/BRIEF.md
# Encoded Ratio Controller Clock Divider

This block derives a slower controller clock from a fast source clock. A 3-bit select code chooses one ratio from a fixed, non-linear set: 1, 2, 4, 6, 8, 16, 24 or 32. The divider produces two outputs. The first is a one-cycle tick for clock-enable style use. The second is a divided clock with a 50% duty cycle.

The select code and the enable are captured only while the divider reset is held. The intended sequence is as follows:
- Raise the divider reset.
- Present the code and the enable.
- Drop the divider reset.

After the divider starts, a ready flag rises once ten output periods have elapsed. Downstream logic can be released from reset at that point.

A separate combinational helper takes the source rate in Hz. It returns the smallest code whose output rate stays at or below a ceiling, which defaults to 300 MHz. Software or a boot sequencer can feed that code straight back into the select input.

Top module: `ctl_clk_div`

## Requirements
- R1: For select codes 1 to 4 the tick is high in one cycle out of every 2 times the code (ratios 2, 4, 6, 8). After the divider reset is released, the tick is first high in cycle number ratio-1, counting the release cycle as cycle 0.
- R2: For select codes 5 to 7 the tick is high in one cycle out of every 8 times (code minus 3) (ratios 16, 24, 32), with the same phase as R1.
- R3: Select code 0 divides by 1. The tick is high in every cycle while the divider runs, and the divided clock output follows the source clock.
- R4: The select code and the enable are captured only while the divider reset is high. Changes to them while the divider runs have no effect on the outputs.
- R5: While the divider reset is high, or after the block reset, the tick, the divided clock and ready are all low.
- R6: If the enable was low when the divider reset was released, the divider stays stopped. The tick, the divided clock and ready all stay low.
- R7: For ratios of 2 or more, the divided clock is low during the first half of each period (counter phase 0 to ratio/2-1) and high during the second half.
- R8: Ready rises in the cycle after the tenth tick since release. It stays high until the next divider reset.
- R9: The recommended code is the smallest c such that the source rate is at most ratio(c) times the ceiling, and 7 when no such c exists. With the default ceiling the thresholds are 300M, 600M, 1.2G, 1.8G, 2.4G, 4.8G and 7.2G.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| div_rst | input | 1 | Divider reset; code and enable are captured while it is high |
| clk_en | input | 1 | Divider enable, captured during divider reset |
| sel_code | input | 3 | Ratio select code |
| src_rate_hz | input | RATE_W | Source clock rate in Hz, used by the code helper |
| tick | output | 1 | One source cycle high per output period |
| div_clk | output | 1 | Divided clock, 50% duty (the source clock for ratio 1) |
| ready | output | 1 | High once ten output periods have elapsed since release |
| rec_code | output | 3 | Smallest code whose output rate stays within the ceiling |

## Verification
Counting the release cycle as cycle 0, the tick, the divided clock and ready for cycle j depend only on j modulo the ratio and on the number of ticks seen before j. The outputs settle on the clock edge that begins cycle j. The driver pushes one expected item per clock edge during every reset and run window. The monitor pops one item 3 ns after each rising edge and compares all three outputs there. The recommended code is combinational, so it is checked 1 ns after each new rate value is applied.

// File: rtl/ctl_clk_div.sv
module ctl_clk_div #(
  parameter int RATE_W      = 34,
  parameter int CEIL_HZ     = 300_000_000,
  parameter int READY_TICKS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_rst,
  input  logic              clk_en,
  input  logic [2:0]        sel_code,
  input  logic [RATE_W-1:0] src_rate_hz,
  output logic              tick,
  output logic              div_clk,
  output logic              ready,
  output logic [2:0]        rec_code
);
  localparam int MAX_RATIO = 32;
  localparam int CNT_W     = $clog2(MAX_RATIO);
  localparam int RDY_W     = $clog2(READY_TICKS + 1);
  localparam int LIM_W     = RATE_W + 7;

  function automatic logic [5:0] code_ratio(input logic [2:0] c);
    if (c == 3'd0)      return 6'd1;
    else if (c <= 3'd4) return {2'b00, c, 1'b0};
    else                return {c - 3'd3, 3'b000};
  endfunction

  logic [2:0]       sel_q;
  logic             en_q;
  logic [CNT_W-1:0] cnt;
  logic             tog;
  logic [RDY_W-1:0] rdy_cnt;
  logic [5:0]       ratio;
  logic [CNT_W-1:0] last, half_m1;
  logic             run;

  assign ratio   = code_ratio(sel_q);
  assign last    = CNT_W'(ratio - 6'd1);
  assign half_m1 = CNT_W'((ratio >> 1) - 6'd1);
  assign run     = en_q && !div_rst;
  assign tick    = run && (cnt == last);
  assign ready   = (rdy_cnt == RDY_W'(READY_TICKS));
  assign div_clk = (run && ratio == 6'd1) ? clk : tog;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= 1'b0;
    end else if (div_rst) begin
      sel_q <= sel_code;
      en_q  <= clk_en;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (div_rst) cnt <= '0;
    else if (run)     cnt <= (cnt == last) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       tog <= 1'b0;
    else if (div_rst) tog <= 1'b0;
    else if (run && ratio > 6'd1 && (cnt == last || cnt == half_m1))
      tog <= ~tog;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                rdy_cnt <= '0;
    else if (div_rst)          rdy_cnt <= '0;
    else if (tick && !ready)   rdy_cnt <= rdy_cnt + 1'b1;

  always_comb begin
    rec_code = 3'd7;
    for (int c = 6; c >= 0; c--)
      if (LIM_W'(src_rate_hz) <= LIM_W'(code_ratio(3'(c))) * LIM_W'(CEIL_HZ))
        rec_code = 3'(c);
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio > 6'd1) |=> !tick); // R1

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_rst && !$past(div_rst)) |-> ($stable(sel_q) && $stable(en_q))); // R4

  AST_QUIET_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(div_rst) |-> (!tog && !ready)); // R5

  AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!tick && !tog && !ready)); // R6

  AST_CLK_LOW_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio > 6'd1 && !div_rst) |=> (div_rst || !tog)); // R7

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !div_rst) |=> ready); // R8

  AST_REC_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_code != 3'd7) |->
      (LIM_W'(src_rate_hz) <= LIM_W'(code_ratio(rec_code)) * LIM_W'(CEIL_HZ))); // R9
endmodule

// File: tb/test_ctl_clk_div.sv
module test_ctl_clk_div;
  localparam int RW = 34;
  logic clk = 1'b0, rst_n = 1'b0, div_rst = 1'b1, clk_en = 1'b0;
  logic [2:0] sel_code = 3'd0;
  logic [RW-1:0] src_rate_hz = '0;
  logic tick, div_clk, ready;
  logic [2:0] rec_code;
  int checks = 0, fails = 0;

  typedef struct { bit t; bit d; bit r; string req; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  ctl_clk_div i_ctl_clk_div (
    .clk(clk), .rst_n(rst_n), .div_rst(div_rst), .clk_en(clk_en),
    .sel_code(sel_code), .src_rate_hz(src_rate_hz), .tick(tick),
    .div_clk(div_clk), .ready(ready), .rec_code(rec_code));

  function automatic int ratio_of(int c);
    if (c == 0) return 1;
    if (c <= 4) return 2 * c;
    return 8 * (c - 3);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(tick == e.t, e.req, "tick", tick, e.t);
      check(div_clk == e.d, e.req, "div_clk", div_clk, e.d);
      check(ready == e.r, e.req, "ready", ready, e.r);
    end
  end

  task automatic push(bit t, bit d, bit r, string req);
    exp_t e;
    e.t = t; e.d = d; e.r = r; e.req = req;
    q.push_back(e);
  endtask

  // Hold the divider reset for 3 edges, release, run n edges.
  task automatic run(int code, bit en, int n, string req, bit poke);
    int r = ratio_of(code);
    int ticks = 0;
    @(negedge clk);
    div_rst = 1'b1; sel_code = 3'(code); clk_en = en;
    for (int k = 0; k < 3; k++) begin
      push(0, 0, 0, "R5");
      @(negedge clk);
    end
    div_rst = 1'b0;
    if (poke) begin sel_code = 3'd7; clk_en = 1'b0; end
    if (en && r == 1) ticks = 1;
    for (int j = 1; j <= n; j++) begin
      bit t, d, rd;
      rd = en && (ticks >= 10);
      t  = en && ((j % r) == r - 1);
      d  = en && ((r == 1) ? 1'b1 : ((j % r) >= r / 2));
      push(t, d, rd, req);
      if (t) ticks++;
      @(negedge clk);
    end
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [RW-1:0] rates [12];
    logic [2:0]    codes [12];
    rates = '{34'd0, 34'd300000000, 34'd300000001, 34'd600000000, 34'd600000001,
              34'd1200000000, 34'd1800000000, 34'd2400000000, 34'd2400000001,
              34'd4800000000, 34'd7200000000, 34'd7200000001};
    codes = '{3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd4, 3'd5, 3'd5, 3'd6, 3'd7};
    #12;
    check(tick == 0 && ready == 0 && div_clk == 0, "R5", "reset outputs",
          {tick, div_clk, ready}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      src_rate_hz = rates[i];
      #1;
      check(rec_code == codes[i], "R9", "rec_code", rec_code, codes[i]);
    end
    run(0, 1, 20, "R3", 0);
    run(1, 1, 30, "R1", 0);
    run(2, 1, 50, "R4", 1);
    run(3, 1, 70, "R7", 0);
    run(4, 1, 95, "R8", 0);
    run(5, 1, 180, "R2", 0);
    run(6, 1, 270, "R2", 0);
    run(7, 1, 360, "R2", 0);
    run(1, 0, 30, "R6", 0);
    run(2, 1, 12, "R1", 0);
    @(negedge clk);
    div_rst = 1'b1;
    push(0, 0, 0, "R5");
    push(0, 0, 0, "R5");
    @(negedge clk);
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule